// File: doc/BRIEF.md
# Triggered Waveform Capture Buffer

This block records a stream of multi-channel sample words into on-chip storage at the full rate of the control loop. Every sample that arrives with its valid strobe is stored. The block behaves like an oscilloscope in single-shot mode. After an arm command it writes samples into a ring and watches one selected channel for a rising or falling crossing of a programmable level. When the crossing occurs, it keeps a chosen number of samples from before the event, completes the window with samples from after it, and then freezes.

A slower processor then reads the frozen record one word at a time. Read address 0 always holds the oldest sample of the window. Because the record is frozen, no sample is lost however slowly it is read. A force input lets software take a capture when no crossing ever occurs. A new arm command discards the record and starts over.

Top module: `cap_buffer`

## Requirements
- R1: After reset, `done_o` is 0 and `trig_idx_o` is 0.
- R2: `arm_i` restarts capture from any state, including mid-window and after completion. In the cycle after `arm_i`, `done_o` is 0, the write slot is 0 and the sample count is cleared. No sample is stored in the arm cycle.
- R3: While capturing, every sample presented with `valid_i` high is stored in consecutive slots, one per valid cycle, with no sample skipped.
- R4: A trigger is accepted only on a valid sample that has at least the pre-trigger depth of samples stored before it since arming.
- R5: With `edge_fall_i`=0, a trigger is a valid sample whose selected channel is at or above `level_i` while the previous stored sample of that channel is below it. The comparison is signed two's complement. Channel k occupies bits [k*DATA_W +: DATA_W] of `sample_i`.
- R6: With `edge_fall_i`=1, a trigger is a valid sample whose selected channel is at or below `level_i` while the previous stored sample is above it.
- R7: `force_i` high on a valid sample that meets R4 triggers on that sample, whatever the channel data.
- R8: The window holds DEPTH-`pre_depth` samples, counted from the trigger sample on. After the last of them, `done_o` rises and stays high until the next arm. Further valid samples are not stored and leave `trig_idx_o` unchanged.
- R9: While done, `rd_data_o` shows the window word at offset `rd_addr_i` one clock after the address is applied. Offset 0 is the oldest pre-trigger sample, and the trigger sample sits at offset `pre_depth`.
- R10: `trig_idx_o` is the slot of the trigger sample. This equals the number of valid samples stored before it since arming, modulo DEPTH.
- R11: The pre-trigger depth is taken from `pre_depth_i` in the arm cycle. Later changes to `pre_depth_i` have no effect until the next arm.
- R12: Cycles with `valid_i` low store nothing. They do not count as samples and do not take part in edge detection.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| valid_i | input | 1 | Sample strobe |
| sample_i | input | N_CH*DATA_W | Packed channel samples |
| arm_i | input | 1 | Start or restart a capture |
| force_i | input | 1 | Trigger without a level crossing |
| src_sel_i | input | SEL_W | Channel watched by the trigger |
| level_i | input | DATA_W | Signed trigger level |
| edge_fall_i | input | 1 | 0 for a rising crossing, 1 for a falling crossing |
| pre_depth_i | input | ADDR_W | Samples kept before the trigger |
| rd_addr_i | input | ADDR_W | Read offset within the window |
| rd_data_o | output | N_CH*DATA_W | Read word, one cycle latency |
| done_o | output | 1 | Window complete and frozen |
| trig_idx_o | output | ADDR_W | Storage slot of the trigger sample |

## Verification
The assertions assume that `arm_i` is a single-cycle pulse and that `valid_i` is low in the arm cycle. They also assume that the trigger settings stay stable while a sample is being judged. The bench drives the arm only through a task that holds the strobe low and pulses the command for exactly one cycle. Random samples, random strobe gaps and random level settings are applied only between arm pulses. `pre_depth_i` is deliberately changed after an arm to show that it is ignored.

// File: rtl/cap_pkg.sv
package cap_pkg;
  typedef enum logic [1:0] {
    ST_IDLE,
    ST_ARMED,
    ST_POST,
    ST_DONE
  } cap_state_e;
endpackage

// File: rtl/cap_trig.sv
module cap_trig #(
  parameter int DATA_W = 12,
  parameter int N_CH   = 2,
  parameter int SEL_W  = 1
) (
  input  logic                     clk_i,
  input  logic                     rst_ni,
  input  logic [N_CH*DATA_W-1:0]   sample_i,
  input  logic [SEL_W-1:0]         sel_i,
  input  logic [DATA_W-1:0]        level_i,
  input  logic                     fall_i,
  input  logic                     wr_en_i,
  output logic                     hit_o
);
  logic [DATA_W-1:0] ch [N_CH];
  logic [DATA_W-1:0] cur, prev_q;

  for (genvar g = 0; g < N_CH; g++) begin : g_ch
    assign ch[g] = sample_i[g*DATA_W +: DATA_W];
  end

  always_comb begin
    cur = ch[0];
    for (int k = 0; k < N_CH; k++)
      if (32'(sel_i) == k) cur = ch[k];
  end

  // previous stored value of the watched channel
  always_ff @(posedge clk_i or negedge rst_ni)
    if (!rst_ni)      prev_q <= '0;
    else if (wr_en_i) prev_q <= cur;

  always_comb begin
    if (fall_i)
      hit_o = ($signed(prev_q) > $signed(level_i)) && ($signed(cur) <= $signed(level_i));
    else
      hit_o = ($signed(prev_q) < $signed(level_i)) && ($signed(cur) >= $signed(level_i));
  end
endmodule

// File: rtl/cap_mem.sv
module cap_mem #(
  parameter int WORD_W = 24,
  parameter int ADDR_W = 6
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              we_i,
  input  logic [ADDR_W-1:0] waddr_i,
  input  logic [WORD_W-1:0] wdata_i,
  input  logic [ADDR_W-1:0] raddr_i,
  output logic [WORD_W-1:0] rdata_o
);
  localparam int DEPTH = 1 << ADDR_W;
  logic [WORD_W-1:0] mem_q [DEPTH];

  always_ff @(posedge clk_i)
    if (we_i) mem_q[waddr_i] <= wdata_i;

  always_ff @(posedge clk_i or negedge rst_ni)
    if (!rst_ni) rdata_o <= '0;
    else         rdata_o <= mem_q[raddr_i];
endmodule

// File: rtl/cap_ctrl.sv
module cap_ctrl
  import cap_pkg::*;
#(
  parameter int ADDR_W = 6
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              valid_i,
  input  logic              arm_i,
  input  logic              force_i,
  input  logic              edge_hit_i,
  input  logic [ADDR_W-1:0] pre_depth_i,
  output cap_state_e        state_o,
  output logic              wr_en_o,
  output logic [ADDR_W-1:0] wr_ptr_o,
  output logic [ADDR_W-1:0] trig_idx_o,
  output logic [ADDR_W-1:0] pre_o,
  output logic [ADDR_W:0]   fill_o,
  output logic              done_o
);
  localparam int FILL_W = ADDR_W + 1;
  localparam int DEPTH  = 1 << ADDR_W;

  cap_state_e        state_q;
  logic [ADDR_W-1:0] wr_ptr_q, trig_q, pre_q, post_q, post_len;
  logic [FILL_W-1:0] fill_q;
  logic              capturing, qualified, fire;

  assign capturing = (state_q == ST_ARMED) || (state_q == ST_POST);
  assign wr_en_o   = valid_i && capturing && !arm_i;
  assign qualified = fill_q >= {1'b0, pre_q};
  // edge needs a previous stored sample, force does not
  assign fire      = qualified && (force_i || (edge_hit_i && (fill_q != '0)));
  assign post_len  = ADDR_W'(DEPTH - 1) - pre_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      state_q  <= ST_IDLE;
      wr_ptr_q <= '0;
      trig_q   <= '0;
      pre_q    <= '0;
      post_q   <= '0;
      fill_q   <= '0;
    end else if (arm_i) begin
      state_q  <= ST_ARMED;
      wr_ptr_q <= '0;
      pre_q    <= pre_depth_i;
      post_q   <= '0;
      fill_q   <= '0;
    end else if (wr_en_o) begin
      wr_ptr_q <= wr_ptr_q + 1'b1;
      if (fill_q != FILL_W'(DEPTH)) fill_q <= fill_q + 1'b1;
      if (state_q == ST_ARMED) begin
        if (fire) begin
          trig_q  <= wr_ptr_q;
          post_q  <= post_len;
          state_q <= (post_len == '0) ? ST_DONE : ST_POST;
        end
      end else begin
        post_q <= post_q - 1'b1;
        if (post_q == ADDR_W'(1)) state_q <= ST_DONE;
      end
    end
  end

  assign state_o    = state_q;
  assign wr_ptr_o   = wr_ptr_q;
  assign trig_idx_o = trig_q;
  assign pre_o      = pre_q;
  assign fill_o     = fill_q;
  assign done_o     = (state_q == ST_DONE);
endmodule

// File: rtl/cap_buffer.sv
module cap_buffer
  import cap_pkg::*;
#(
  parameter int DATA_W = 12,
  parameter int N_CH   = 2,
  parameter int ADDR_W = 6,
  localparam int SEL_W  = (N_CH > 1) ? $clog2(N_CH) : 1,
  localparam int WORD_W = N_CH * DATA_W
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              valid_i,
  input  logic [WORD_W-1:0] sample_i,
  input  logic              arm_i,
  input  logic              force_i,
  input  logic [SEL_W-1:0]  src_sel_i,
  input  logic [DATA_W-1:0] level_i,
  input  logic              edge_fall_i,
  input  logic [ADDR_W-1:0] pre_depth_i,
  input  logic [ADDR_W-1:0] rd_addr_i,
  output logic [WORD_W-1:0] rd_data_o,
  output logic              done_o,
  output logic [ADDR_W-1:0] trig_idx_o
);
  cap_state_e        state;
  logic              wr_en, edge_hit;
  logic [ADDR_W-1:0] wr_ptr, pre_q, rd_phys;
  logic [ADDR_W:0]   fill;

  cap_trig #(.DATA_W(DATA_W), .N_CH(N_CH), .SEL_W(SEL_W)) i_trig (
    .clk_i, .rst_ni, .sample_i,
    .sel_i   (src_sel_i),
    .level_i,
    .fall_i  (edge_fall_i),
    .wr_en_i (wr_en),
    .hit_o   (edge_hit)
  );

  cap_ctrl #(.ADDR_W(ADDR_W)) i_ctrl (
    .clk_i, .rst_ni, .valid_i, .arm_i, .force_i,
    .edge_hit_i  (edge_hit),
    .pre_depth_i,
    .state_o     (state),
    .wr_en_o     (wr_en),
    .wr_ptr_o    (wr_ptr),
    .trig_idx_o,
    .pre_o       (pre_q),
    .fill_o      (fill),
    .done_o
  );

  // offset 0 maps to the oldest pre-trigger slot
  assign rd_phys = trig_idx_o - pre_q + rd_addr_i;

  cap_mem #(.WORD_W(WORD_W), .ADDR_W(ADDR_W)) i_mem (
    .clk_i, .rst_ni,
    .we_i    (wr_en),
    .waddr_i (wr_ptr),
    .wdata_i (sample_i),
    .raddr_i (rd_phys),
    .rdata_o (rd_data_o)
  );
endmodule

// File: rtl/cap_buffer_chk.sv
module cap_buffer_chk
  import cap_pkg::*;
#(
  parameter int ADDR_W = 6
) (
  input logic              clk_i,
  input logic              rst_ni,
  input logic              arm_i,
  input logic              valid_i,
  input logic              done_i,
  input logic [ADDR_W-1:0] trig_idx_i,
  input logic              wr_en_i,
  input cap_state_e        state_i,
  input logic [ADDR_W:0]   fill_i,
  input logic [ADDR_W-1:0] pre_i
);
  // R2
  arm_clears_done_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    arm_i |=> !done_i);
  // R8
  done_holds_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done_i && !arm_i |=> done_i && $stable(trig_idx_i));
  // R8
  frozen_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done_i |-> !wr_en_i);
  // R12
  no_write_without_valid_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    wr_en_i |-> valid_i);
  // R4
  qualify_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (state_i == ST_ARMED) && (fill_i < {1'b0, pre_i}) |=> state_i == ST_ARMED);
  // R2
  arm_restart_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    arm_i |=> (state_i == ST_ARMED) && (fill_i == '0));
endmodule

bind cap_buffer cap_buffer_chk #(.ADDR_W(ADDR_W)) i_chk (
  .clk_i      (clk_i),
  .rst_ni     (rst_ni),
  .arm_i      (arm_i),
  .valid_i    (valid_i),
  .done_i     (done_o),
  .trig_idx_i (trig_idx_o),
  .wr_en_i    (wr_en),
  .state_i    (state),
  .fill_i     (fill),
  .pre_i      (pre_q)
);

// File: tb/test_cap_buffer.sv
module test_cap_buffer;
  localparam int DW = 12;
  localparam int NC = 2;
  localparam int AW = 6;
  localparam int DEPTH = 1 << AW;
  localparam int WW = NC * DW;
  localparam int HMAX = 4096;

  logic clk = 0, rst_ni = 0;
  logic valid_i = 0, arm_i = 0, force_i = 0, edge_fall_i = 0;
  logic [WW-1:0] sample_i = '0;
  logic [0:0] src_sel_i = '0;
  logic [DW-1:0] level_i = '0;
  logic [AW-1:0] pre_depth_i = '0, rd_addr_i = '0;
  logic [WW-1:0] rd_data_o;
  logic done_o;
  logic [AW-1:0] trig_idx_o;

  int errors = 0, checks = 0;
  bit finished = 0;

  // bench model
  logic [WW-1:0] hist [HMAX];
  int n, tpos, pre_m, sel_m;
  bit trig_m, fall_m;
  logic [DW-1:0] lvl_m;

  always #4 clk = ~clk;

  cap_buffer #(.DATA_W(DW), .N_CH(NC), .ADDR_W(AW)) i_cap_buffer (
    .clk_i(clk), .rst_ni, .valid_i, .sample_i, .arm_i, .force_i, .src_sel_i,
    .level_i, .edge_fall_i, .pre_depth_i, .rd_addr_i, .rd_data_o, .done_o, .trig_idx_o
  );

  task automatic chk(input bit ok, input string req, input longint act, input longint exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  function automatic logic [DW-1:0] chan(input logic [WW-1:0] w, input int s);
    return w[s*DW +: DW];
  endfunction

  function automatic bit crossing(input logic [DW-1:0] p, input logic [DW-1:0] c);
    if (fall_m) return ($signed(p) > $signed(lvl_m)) && ($signed(c) <= $signed(lvl_m));
    return ($signed(p) < $signed(lvl_m)) && ($signed(c) >= $signed(lvl_m));
  endfunction

  function automatic bit done_m();
    return trig_m && (n >= tpos + DEPTH - pre_m);
  endfunction

  task automatic do_arm(input int pre, input int sel, input bit fall, input logic [DW-1:0] lvl);
    @(negedge clk);
    valid_i = 0; force_i = 0; arm_i = 1;
    pre_depth_i = AW'(pre); src_sel_i = 1'(sel); edge_fall_i = fall; level_i = lvl;
    @(negedge clk);
    arm_i = 0;
    n = 0; trig_m = 0; tpos = 0; pre_m = pre; sel_m = sel; fall_m = fall; lvl_m = lvl;
    chk(done_o == 1'b0, "R2 done cleared after arm", done_o, 0);
  endtask

  // drive one cycle at the current negedge, sample at the next
  task automatic push(input bit v, input logic [WW-1:0] w, input bit f);
    valid_i = v; sample_i = w; force_i = f;
    @(negedge clk);
    valid_i = 0; force_i = 0;
    if (v && !done_m()) begin
      if (!trig_m && n >= pre_m &&
          (f || (n > 0 && crossing(chan(hist[n-1], sel_m), chan(w, sel_m))))) begin
        trig_m = 1; tpos = n;
      end
      hist[n] = w;
      n++;
    end
    chk(done_o == done_m(), "R8 done timing", done_o, done_m());
  endtask

  task automatic fill_random(input int pct, input int force_from);
    while (!done_m()) begin
      bit v = ($urandom % 100) < pct;
      push(v, WW'($urandom), n >= force_from);
    end
  endtask

  task automatic verify_record(input string tag);
    chk(trig_idx_o == AW'(tpos % DEPTH), "R10 trigger slot", trig_idx_o, tpos % DEPTH);
    // R8: extra samples after completion must not alter the record
    for (int k = 0; k < 5; k++) push(1'b1, WW'($urandom), 1'b1);
    chk(trig_idx_o == AW'(tpos % DEPTH), "R8 trigger slot frozen", trig_idx_o, tpos % DEPTH);
    for (int a = 0; a < DEPTH; a++) begin
      rd_addr_i = AW'(a);
      @(negedge clk);
      chk(rd_data_o == hist[tpos - pre_m + a], {"R9 R3 window word ", tag},
          rd_data_o, hist[tpos - pre_m + a]);
    end
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    if (!finished) begin
      errors++; checks++;
      $display("FAIL watchdog expired actual=0 expected=1");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end

  initial begin
    void'($urandom(32'd4711));
    repeat (3) @(negedge clk);
    // R1
    chk(done_o == 1'b0, "R1 reset done", done_o, 0);
    chk(trig_idx_o == '0, "R1 reset trig_idx", trig_idx_o, 0);
    rst_ni = 1;
    @(negedge clk);
    chk(done_o == 1'b0, "R1 idle after reset", done_o, 0);

    // R5 rising, random data and strobe gaps (R12)
    do_arm(10, 0, 1'b0, 12'sd100);
    fill_random(70, 3000);
    verify_record("R5 rising");

    // R6 falling, channel 1, no pre-trigger history
    do_arm(0, 1, 1'b1, -12'sd200);
    fill_random(60, 3000);
    verify_record("R6 falling");

    // R7 force only, maximal pre depth; level unreachable for a rising crossing
    do_arm(DEPTH - 1, 0, 1'b0, 12'h800);
    fill_random(80, 70);
    chk(tpos == 70, "R7 forced trigger position", tpos, 70);
    verify_record("R7 force");

    // R4: early crossing ignored, later crossing accepted (channel 0, level 0)
    do_arm(8, 0, 1'b0, 12'd0);
    push(1, {12'd0, -12'sd5}, 0);
    push(1, {12'd0, -12'sd5}, 0);
    push(1, {12'd0, 12'sd5}, 0);        // crossing at 2, not qualified
    for (int k = 0; k < 7; k++) push(1, {12'd0, 12'sd5}, 0);
    push(0, {12'd0, -12'sd9}, 0);       // R12: gap cycle does not count
    push(1, {12'd0, -12'sd3}, 0);
    push(1, {12'd0, 12'sd7}, 0);        // qualified crossing at 11
    chk(trig_m && tpos == 11, "R4 qualified trigger index", tpos, 11);
    fill_random(90, 3000);
    verify_record("R4 directed");

    // R2 re-arm mid window, then R11 depth latched at arm
    do_arm(4, 0, 1'b0, 12'd0);
    while (!(trig_m && n >= tpos + 10)) push(1, WW'($urandom), n >= 6);
    do_arm(20, 1, 1'b0, 12'sd50);
    pre_depth_i = AW'(3);               // R11: ignored after arm
    chk(done_o == 1'b0, "R2 no completion after re-arm", done_o, 0);
    fill_random(75, 3000);
    verify_record("R11 latched depth");

    // random sweep
    for (int r = 0; r < 6; r++) begin
      do_arm(int'($urandom % DEPTH), int'($urandom % NC), 1'($urandom), DW'($urandom));
      fill_random(50 + int'($urandom % 50), 1500);
      verify_record("R3 random");
    end

    finished = 1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule